// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that walks a chain of descriptors held in memory. Software writes the address of the first descriptor into the channel's register window and then sets the enable bit. The channel reads the descriptor's six 32-bit words through a memory master port. It then copies the requested number of bytes from the source address to the destination address, one element per beat. After that it either follows the descriptor's link word to the next descriptor or stops when the link holds the end-of-chain marker.

Each descriptor holds six words at consecutive word addresses, in this order: configuration, source address, destination address, byte count, parameter, link. The configuration word selects the element size and chooses, for each side, between an address that steps forward and a fixed address. The parameter word sets a number of idle cycles to insert between beats. Every completed descriptor produces a one-clock event pulse. Software can pause the channel between beats, halt it, and read back its progress.

The memory port carries one request per cycle. A read returns its data, with a valid strobe, one cycle after the request. A write completes in the cycle of its request.

Top module: `dmaChainTop`

## Requirements
- R1: A register write of 1 in bit 0 at offset 0x00 while idle starts the channel. It then reads six words with memSize code 2 from the start address held at offset 0x08, at ascending word addresses. Bit 0 of a read at offset 0x00 shows busy.
- R2: Config bits 10:9 select the element size: codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Each beat reads one element from the current source and writes it to the current destination. Both requests carry that code on memSize, and the data is right-aligned and little-endian.
- R3: Config bit 5 sets the source mode and bit 21 sets the destination mode. A 0 advances that address by the element size after each beat. A 1 keeps it fixed.
- R4: The bytes-left count is reduced by the element size after each beat, stopping at 0, and the descriptor completes when it reaches 0. A count that is not a multiple of the element size ends with one full final element. A count of 0 moves no data.
- R5: Parameter bits 7:0 hold a wait value W. With 1-cycle read latency, consecutive data writes within one descriptor are exactly 3+W cycles apart.
- R6: pkgEnd is high for exactly one clock per completed descriptor: the cycle after its last data write, or the cycle after its last word is fetched when its count is 0.
- R7: A link word of 0xFFFFF800 ends the chain and busy clears. Any other link value makes the channel fetch the next descriptor at that address.
- R8: A register write of 0 in bit 0 at offset 0x00 halts the channel. There is no memory request from the next cycle on, and busy reads 0.
- R9: While bit 0 at offset 0x04 is set, no new beat starts, and the offset reads back the bit. Clearing it resumes the transfer.
- R10: Readback offsets: 0x0C gives the current config word, 0x10 the current source address, 0x14 the current destination address, 0x18 the bytes left, and 0x1C the parameter word.
- R11: The burst-length fields (config bits 7:6 and 23:22), the request-type fields (bits 4:0 and 20:16) and the destination width field (bits 26:25) have no effect on the data moved or on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Byte offset within the channel window |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory request |
| memWr | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address |
| memSize | output | 2 | log2 of the access size in bytes |
| memWdata | output | 64 | Write data, right-aligned |
| memRdata | input | 64 | Read data, right-aligned |
| memRdValid | input | 1 | Read data valid |
| pkgEnd | output | 1 | One-clock descriptor-complete pulse |

## Verification
A data beat takes three cycles: read request, wait for data, then write. The next beat's read follows W idle cycles later, so the bench measures the distance between write strobes and expects exactly 3+W. pkgEnd is counted at the clock edge in the cycle after the last write, and a halt is checked at the first cycle after the register write. The bench drives its inputs and samples its outputs on the falling clock edge. It reads the registers only after busy has dropped, or at fixed cycle counts while the channel is paused, so every expected value is already settled when it is compared.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_RD, ST_RWAIT, ST_WR, ST_GAP, ST_DONE
  } chanState_t;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadStart;
    logic     fetchLatch;
    logic     dataLatch;
    logic     beatStep;
    logic     followLink;
    logic     gapLoad;
    logic     gapTick;
    logic     memReq;
    logic     memWr;
    addrSel_t addrSel;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic fetchLast;
    logic lastBeat;
    logic countZero;
    logic chainEnd;
    logic waitZero;
    logic gapDone;
  } dpFlags_t;

endpackage

// File: rtl/dmaChainControl.sv
module dmaChainControl
  import dmaChainPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       haltReq,
  input  logic       pauseOn,
  input  logic       memRdValid,
  input  dpFlags_t   flags,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       pkgEnd
);

  chanState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strb   = '0;
    pkgEnd = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadStart = 1'b1;
          nxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strb.memReq  = 1'b1;
        strb.addrSel = SEL_DESC;
        nxt = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (memRdValid) begin
          strb.fetchLatch = 1'b1;
          if (!flags.fetchLast)      nxt = ST_FETCH;
          else if (flags.countZero)  nxt = ST_DONE;
          else                       nxt = ST_RD;
        end
      end
      ST_RD: begin
        if (!pauseOn) begin
          strb.memReq  = 1'b1;
          strb.addrSel = SEL_SRC;
          nxt = ST_RWAIT;
        end
      end
      ST_RWAIT: begin
        if (memRdValid) begin
          strb.dataLatch = 1'b1;
          nxt = ST_WR;
        end
      end
      ST_WR: begin
        strb.memReq   = 1'b1;
        strb.memWr    = 1'b1;
        strb.addrSel  = SEL_DST;
        strb.beatStep = 1'b1;
        if (flags.lastBeat)     nxt = ST_DONE;
        else if (flags.waitZero) nxt = ST_RD;
        else begin
          strb.gapLoad = 1'b1;
          nxt = ST_GAP;
        end
      end
      ST_GAP: begin
        strb.gapTick = 1'b1;
        if (flags.gapDone) nxt = ST_RD;
      end
      ST_DONE: begin
        pkgEnd = 1'b1;
        if (flags.chainEnd) nxt = ST_IDLE;
        else begin
          strb.followLink = 1'b1;
          nxt = ST_FETCH;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (haltReq) nxt = ST_IDLE;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dmaChainDatapath.sv
module dmaChainDatapath
  import dmaChainPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DATA_W     = 64,
  parameter int REG_AW     = 6,
  parameter int WAIT_W     = 8,
  parameter int DESC_WORDS = 6,
  parameter logic [WORD_W-1:0] END_MARK = 32'hFFFFF800
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic              busy,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output dpFlags_t          flags,
  output logic              pauseOn
);

  localparam int IDX_W   = $clog2(DESC_WORDS);
  localparam int WORD_SH = $clog2(WORD_W / 8);
  localparam int SIZE_LSB  = 9;
  localparam int SRC_FIXED = 5;
  localparam int DST_FIXED = 21;
  localparam logic [REG_AW-1:0] OFF_EN    = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] OFF_PAUSE = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] OFF_START = REG_AW'(8'h08);
  localparam logic [REG_AW-1:0] OFF_CFG   = REG_AW'(8'h0C);
  localparam logic [REG_AW-1:0] OFF_SRC   = REG_AW'(8'h10);
  localparam logic [REG_AW-1:0] OFF_DST   = REG_AW'(8'h14);
  localparam logic [REG_AW-1:0] OFF_LEFT  = REG_AW'(8'h18);
  localparam logic [REG_AW-1:0] OFF_PARA  = REG_AW'(8'h1C);

  logic [WORD_W-1:0] startAddr, descAddr, cfgWord, srcAddr, dstAddr;
  logic [WORD_W-1:0] bytesLeft, paraWord, linkWord;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] dataBuf;
  logic [WAIT_W-1:0] gapCnt;
  logic [1:0]        sizeCode;
  logic [WORD_W-1:0] elemBytes;
  logic [WORD_W-1:0] fetchWord;

  assign sizeCode  = cfgWord[SIZE_LSB+1:SIZE_LSB];
  assign elemBytes = WORD_W'(1) << sizeCode;
  assign fetchWord = memRdata[WORD_W-1:0];

  // software-written registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      pauseOn   <= 1'b0;
    end else if (regWe) begin
      if (regAddr == OFF_PAUSE) pauseOn <= regWdata[0];
      if (regAddr == OFF_START) startAddr <= {regWdata[WORD_W-1:2], 2'b00};
    end
  end

  // descriptor state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      cfgWord   <= '0;
      srcAddr   <= '0;
      dstAddr   <= '0;
      bytesLeft <= '0;
      paraWord  <= '0;
      linkWord  <= '0;
      idx       <= '0;
    end else begin
      if (strb.loadStart) begin
        descAddr <= startAddr;
        idx      <= '0;
      end
      if (strb.followLink) begin
        descAddr <= linkWord;
        idx      <= '0;
      end
      if (strb.fetchLatch) begin
        case (idx)
          IDX_W'(0): cfgWord   <= fetchWord;
          IDX_W'(1): srcAddr   <= fetchWord;
          IDX_W'(2): dstAddr   <= fetchWord;
          IDX_W'(3): bytesLeft <= fetchWord;
          IDX_W'(4): paraWord  <= fetchWord;
          IDX_W'(5): linkWord  <= fetchWord;
          default: ;
        endcase
        idx <= idx + 1'b1;
      end
      if (strb.beatStep) begin
        if (!cfgWord[SRC_FIXED]) srcAddr <= srcAddr + elemBytes;
        if (!cfgWord[DST_FIXED]) dstAddr <= dstAddr + elemBytes;
        bytesLeft <= (bytesLeft > elemBytes) ? bytesLeft - elemBytes : '0;
      end
    end
  end

  // beat data and inter-beat gap counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBuf <= '0;
      gapCnt  <= '0;
    end else begin
      if (strb.dataLatch) dataBuf <= memRdata;
      if (strb.gapLoad)      gapCnt <= paraWord[WAIT_W-1:0];
      else if (strb.gapTick) gapCnt <= gapCnt - 1'b1;
    end
  end

  always_comb begin
    case (strb.addrSel)
      SEL_SRC: begin memAddr = srcAddr; memSize = sizeCode; end
      SEL_DST: begin memAddr = dstAddr; memSize = sizeCode; end
      default: begin
        memAddr = descAddr + (WORD_W'(idx) << WORD_SH);
        memSize = 2'(WORD_SH);
      end
    endcase
  end
  assign memWdata = dataBuf;

  assign flags.fetchLast = (idx == IDX_W'(DESC_WORDS - 1));
  assign flags.lastBeat  = (bytesLeft <= elemBytes);
  assign flags.countZero = (bytesLeft == '0);
  assign flags.chainEnd  = (linkWord == END_MARK);
  assign flags.waitZero  = (paraWord[WAIT_W-1:0] == '0);
  assign flags.gapDone   = (gapCnt == WAIT_W'(1));

  always_comb begin
    case (regAddr)
      OFF_EN:    regRdata = {{(WORD_W-1){1'b0}}, busy};
      OFF_PAUSE: regRdata = {{(WORD_W-1){1'b0}}, pauseOn};
      OFF_START: regRdata = startAddr;
      OFF_CFG:   regRdata = cfgWord;
      OFF_SRC:   regRdata = srcAddr;
      OFF_DST:   regRdata = dstAddr;
      OFF_LEFT:  regRdata = bytesLeft;
      OFF_PARA:  regRdata = paraWord;
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dmaChainTop.sv
module dmaChainTop
  import dmaChainPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DATA_W = 64,
  parameter int REG_AW = 6,
  parameter int WAIT_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWr,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRdValid,
  output logic              pkgEnd
);

  ctlStrobe_t strb;
  dpFlags_t   flags;
  logic       busy, pauseOn, enWrite, startReq, haltReq;

  assign enWrite  = regWe && (regAddr == '0);
  assign startReq = enWrite && regWdata[0];
  assign haltReq  = enWrite && !regWdata[0];

  dmaChainControl u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .haltReq(haltReq),
    .pauseOn(pauseOn), .memRdValid(memRdValid), .flags(flags),
    .strb(strb), .busy(busy), .pkgEnd(pkgEnd)
  );

  dmaChainDatapath #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .WAIT_W(WAIT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .strb(strb),
    .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .flags(flags), .pauseOn(pauseOn)
  );

  assign memReq = strb.memReq;
  assign memWr  = strb.memWr;

endmodule

// File: rtl/dmaChainChecker.sv
module dmaChainChecker #(
  parameter int REG_AW = 6
)(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              memReq,
  input logic              memWr,
  input logic              pkgEnd,
  input logic              busy
);

  logic haltWr;
  assign haltWr = regWe && (regAddr == '0) && !regWdata[0];

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    pkgEnd |=> !pkgEnd);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    haltWr |=> (!memReq && !busy));

  assert_end_after_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(haltWr)) |-> $past(pkgEnd));

  assert_req_when_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_write_after_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWr) |-> !$past(memReq));

endmodule

bind dmaChainTop dmaChainChecker #(.REG_AW(REG_AW)) u_checker (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .memReq(memReq), .memWr(memWr),
  .pkgEnd(pkgEnd), .busy(busy)
);

// File: tb/dmaChainTop_bench.sv
module dmaChainTop_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWr;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic        memRdValid = 1'b0;
  logic        pkgEnd;

  dmaChainTop u_dmaChainTop (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWr(memWr), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memRdValid(memRdValid),
    .pkgEnd(pkgEnd)
  );

  always #4 clk = ~clk;

  logic [7:0] mem [0:1023];
  int cyc = 0, wrCount = 0, pkgCount = 0, lastWr = -1, minGap = 0, maxGap = 0;
  int checks = 0, fails = 0;
  logic [7:0] expDst [0:63];

  // memory model: 1-cycle read latency, writes take effect at the edge
  always @(posedge clk) begin
    logic [63:0] rd;
    cyc <= cyc + 1;
    memRdValid <= 1'b0;
    if (memReq && !memWr) begin
      rd = '0;
      for (int b = 0; b < 8; b++)
        if (b < (1 << memSize)) rd[8*b +: 8] = mem[(memAddr + b) & 1023];
      memRdata   <= rd;
      memRdValid <= 1'b1;
    end
    if (memReq && memWr) begin
      for (int b = 0; b < 8; b++)
        if (b < (1 << memSize)) mem[(memAddr + b) & 1023] = memWdata[8*b +: 8];
      wrCount = wrCount + 1;
      if (lastWr >= 0) begin
        if (cyc - lastWr < minGap) minGap = cyc - lastWr;
        if (cyc - lastWr > maxGap) maxGap = cyc - lastWr;
      end
      lastWr = cyc;
    end
    if (pkgEnd) pkgCount = pkgCount + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finishRun();
  end

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[(a + b) & 1023] = v[8*b +: 8];
  endtask

  task automatic putDesc(input int a, input logic [31:0] cfg, src, dst, cnt, para, link);
    put32(a, cfg); put32(a+4, src); put32(a+8, dst);
    put32(a+12, cnt); put32(a+16, para); put32(a+20, link);
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      regRead(6'h00, v);
      if (v[0] == 1'b0) return;
    end
    chk(1'b0, "R7 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic clearGaps();
    lastWr = -1; minGap = 1000000; maxGap = 0;
  endtask

  localparam logic [31:0] ENDM = 32'hFFFFF800;

  initial begin
    logic [31:0] v, v2;
    int pk0, wr0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    regRead(6'h00, v); chk(v == 0, "R1 busy after reset", v, 0);
    regRead(6'h18, v); chk(v == 0, "R10 left after reset", v, 0);
    chk(pkgEnd == 1'b0, "R6 pkgEnd after reset", {31'b0, pkgEnd}, 0);

    // sweep: element size x address modes x wait
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 4; m++)
        for (int g = 0; g < 2; g++) begin
          int sz, gw;
          logic [31:0] cfg;
          bit ok;
          sz = 1 << w; gw = g * 2;
          for (int i = 0; i < 64; i++) begin
            mem[256 + i] = 8'((i * 7 + w * 13 + m * 3 + g) | 1);
            mem[512 + i] = 8'h00;
            expDst[i] = 8'h00;
          end
          cfg = (32'(w) << 9) | (32'(m & 1) << 5) | (32'(m >> 1) << 21);
          if (g == 1) cfg |= (32'd3 << 22) | (32'd2 << 6) | (32'h1F << 16) | 32'h0A | (32'(3 - w) << 25);
          putDesc(0, cfg, 32'h100, 32'h200, 32'(4 * sz), 32'(gw), ENDM);
          for (int k = 0; k < 4; k++)
            for (int b = 0; b < sz; b++)
              expDst[((m >> 1) ? 0 : k * sz) + b] = mem[256 + ((m & 1) ? 0 : k * sz) + b];
          pk0 = pkgCount; clearGaps();
          regWrite(6'h08, 32'h0);
          regWrite(6'h00, 32'h1);
          waitIdle();
          ok = 1'b1;
          for (int i = 0; i < 64; i++) if (mem[512 + i] != expDst[i]) ok = 1'b0;
          chk(ok, (g == 1) ? "R2 R11 data copied" : "R2 data copied", {31'b0, ok}, 1);
          regRead(6'h10, v);
          chk(v == ((m & 1) ? 32'h100 : 32'h100 + 32'(4 * sz)), "R3 source address", v,
              (m & 1) ? 32'h100 : 32'h100 + 32'(4 * sz));
          regRead(6'h14, v);
          chk(v == ((m >> 1) ? 32'h200 : 32'h200 + 32'(4 * sz)), "R3 destination address", v,
              (m >> 1) ? 32'h200 : 32'h200 + 32'(4 * sz));
          regRead(6'h18, v); chk(v == 0, "R4 bytes left", v, 0);
          regRead(6'h0C, v); chk(v == cfg, "R10 config readback", v, cfg);
          chk(pkgCount - pk0 == 1, "R6 one pulse per descriptor", 32'(pkgCount - pk0), 1);
          chk(minGap == 3 + gw && maxGap == 3 + gw, (g == 1) ? "R5 R11 beat spacing" : "R5 beat spacing",
              32'(maxGap), 32'(3 + gw));
        end

    // chain of three: copy, zero count, odd count
    for (int i = 0; i < 64; i++) mem[768 + i] = 8'h00;
    putDesc(32'h040, 32'(2) << 9, 32'h100, 32'h300, 8, 0, 32'h080);
    putDesc(32'h080, 32'(2) << 9, 32'h100, 32'h380, 0, 0, 32'h0C0);
    putDesc(32'h0C0, 32'(1) << 9, 32'h110, 32'h320, 5, 32'h11, ENDM);
    pk0 = pkgCount;
    regWrite(6'h08, 32'h040);
    regWrite(6'h00, 32'h1);
    waitIdle();
    chk(pkgCount - pk0 == 3, "R7 chain followed", 32'(pkgCount - pk0), 3);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 8; i++) if (mem[768 + i] != mem[256 + i]) ok = 1'b0;
      chk(ok, "R7 first descriptor data", {31'b0, ok}, 1);
      ok = 1'b1;
      for (int i = 0; i < 6; i++) if (mem[800 + i] != mem[272 + i]) ok = 1'b0;
      chk(ok && mem[806] == 8'h00, "R4 odd count ends on full element", {31'b0, ok}, 1);
      chk(mem[896] == 8'h00, "R4 zero count moves nothing", 32'(mem[896]), 0);
    end
    regRead(6'h18, v); chk(v == 0, "R4 left after odd count", v, 0);
    regRead(6'h1C, v); chk(v == 32'h11, "R10 parameter readback", v, 32'h11);
    regRead(6'h14, v); chk(v == 32'h326, "R10 destination readback", v, 32'h326);

    // pause between beats
    for (int i = 0; i < 8; i++) mem[512 + i] = 8'h00;
    putDesc(0, 32'h0, 32'h100, 32'h200, 4, 0, ENDM);
    regWrite(6'h04, 32'h1);
    wr0 = wrCount;
    regWrite(6'h08, 32'h0);
    regWrite(6'h00, 32'h1);
    repeat (60) @(negedge clk);
    chk(wrCount == wr0, "R9 no beat while paused", 32'(wrCount - wr0), 0);
    regRead(6'h00, v); chk(v == 1, "R9 busy while paused", v, 1);
    regRead(6'h04, v); chk(v == 1, "R9 pause readback", v, 1);
    regRead(6'h10, v); chk(v == 32'h100, "R9 source held", v, 32'h100);
    regWrite(6'h04, 32'h0);
    waitIdle();
    chk(wrCount - wr0 == 4, "R9 resumed beats", 32'(wrCount - wr0), 4);
    chk(mem[515] == mem[259], "R9 resumed data", 32'(mem[515]), 32'(mem[259]));

    // halt in the middle of a long transfer
    putDesc(0, 32'h0, 32'h100, 32'h200, 64, 5, ENDM);
    regWrite(6'h08, 32'h0);
    regWrite(6'h00, 32'h1);
    repeat (100) @(negedge clk);
    regWrite(6'h00, 32'h0);
    regRead(6'h00, v); chk(v == 0, "R8 busy after halt", v, 0);
    wr0 = wrCount;
    repeat (50) @(negedge clk);
    chk(wrCount == wr0, "R8 no writes after halt", 32'(wrCount - wr0), 0);
    regRead(6'h18, v2);
    chk(v2 != 0 && v2 < 64, "R8 stopped mid transfer", v2, 32'd32);
    regRead(6'h00, v); chk(v == 0, "R1 idle stays idle", v, 0);

    finishRun();
  end

endmodule